// File: doc/BRIEF.md
# Register-Triggered Multiply-Accumulate Unit

A memory-mapped arithmetic peripheral for a small processor. Software writes two operand registers and a control register. The unit multiplies the operands, signed or unsigned. It can accumulate the product into, or subtract it from, a three-word accumulator, or it can negate the product. There is no start command. The unit counts operand writes and launches the calculation as soon as the configured number of operands has arrived.

Results are seen in two places. The two-word result view is readable on the cycle after the triggering write in most modes. The three-word accumulator always takes one further cycle, and so does the view when it depends on an accumulator update. A self-clearing clear bit resets the data, the overflow flag and the write counter. Calculations can be triggered on consecutive cycles without wait states.

Top module: `mac_unit`

## Requirements
- R1: The address map is 0 control, 1 operand A, 2 operand B, 3 result low word, 4 result high word, 5/6/7 accumulator words 0/1/2. In two-operand mode, one write to A and one to B, in either order, trigger one calculation.
- R2: In two-operand mode, rewriting the operand already pending replaces it and triggers nothing.
- R3: With control bit 4 set (one-operand mode), every write to A or B triggers at once, using the stored value of the other operand.
- R4: Any write to the control register discards a pending operand count.
- R5: Writing control with bit 5 set zeroes both operands, the accumulator, the result view and the overflow flag, and resets the count. Bit 5 always reads back 0.
- R6: The view shows the new result the cycle after the triggering write, except for accumulate or subtract with bit 2 clear, which take one cycle more. With bit 2 clear, the accumulator shows its old value on the first cycle and the new value on the second.
- R7: Mode field {bit2,bit1,bit0} gives {bit1,bit0} = 00 multiply, 01 accumulate, 10 negate, 11 subtract. Negate is available only with signed data; with bit 3 set, 10 acts as multiply.
- R8: With bit 2 set, the accumulator and the flag are unchanged. The view shows P or −P for multiply and negate, and the low 2W bits of ACC ± P for accumulate and subtract.
- R9: With bit 2 clear, multiply and negate load ±P (extended) into the accumulator and the view. Accumulate and subtract load ACC ± P, and the view shows the low 2W bits of old ACC ± 2·P.
- R10: The overflow flag (control read bit 6) is overwritten by every accumulate or subtract with bit 2 clear. It flags 3W-bit overflow in the selected signedness. All other operations leave it unchanged.
- R11: Operations triggered on consecutive cycles are all applied, in order.
- R12: Writes to addresses 3 to 7 change nothing and trigger nothing.
- R13: Control bit 3 clear treats the operands and accumulator as two's complement; set treats them as unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | BUS_W | Write data (operands use the low W bits) |
| rd_addr | input | 3 | Read address |
| rd_data | output | BUS_W | Read data, combinational from rd_addr |

## Verification
The bench builds the unit with W=4 and BUS_W=8, which gives a 12-bit accumulator and an 8-bit view. This makes every one of the 256 operand pairs reachable in all eight mode codes under both signednesses. Accumulation runs over the whole sweep, so it wraps often and drives the overflow flag both ways, against a model computed with plain integer arithmetic. Directed sequences cover operand ordering, rewrites, counter resets, one-operand mode, back-to-back triggers, ignored writes and clear.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate unit: register addresses,
// operation kinds, control fields and the mode decoder.
package mac_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_OPA  = 3'd1,
        ADR_OPB  = 3'd2,
        ADR_RLO  = 3'd3,
        ADR_RHI  = 3'd4,
        ADR_AC0  = 3'd5,
        ADR_AC1  = 3'd6,
        ADR_AC2  = 3'd7
    } mac_addr_e;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_MAC = 2'd1,
        OP_NEG = 2'd2,
        OP_MSU = 2'd3
    } mac_kind_e;

    // Stored control fields, bit 4 down to bit 0 of the control word.
    typedef struct packed {
        logic single;
        logic unsgn;
        logic view_only;
        logic sub;
        logic mac;
    } mac_ctrl_t;

    localparam int CTRL_FIELDS  = 5;
    localparam int CTRL_CLR_BIT = 5;
    localparam int CTRL_OVF_BIT = 6;

    // Map the control fields to an operation; negate needs signed data.
    function automatic mac_kind_e decode_kind(mac_ctrl_t c);
        mac_kind_e k;
        case ({c.sub, c.mac})
            2'b00:   k = OP_MUL;
            2'b01:   k = OP_MAC;
            2'b10:   k = c.unsgn ? OP_MUL : OP_NEG;
            default: k = OP_MSU;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mac_opseq.sv
// Operand write counter. It decides on which operand write a calculation
// fires. Assumes at most one of wr_opa/wr_opb is high in a cycle.
module mac_opseq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_opa,
    input  logic wr_opb,
    input  logic wr_ctrl,
    input  logic single,
    output logic fire
);

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_HAVE_A, SEQ_HAVE_B} seq_e;
    seq_e st_q, st_d;

    // Fire decision: any write in one-operand mode, else the opposite side.
    always_comb begin
        if (single) fire = wr_opa | wr_opb;
        else        fire = (wr_opa && st_q == SEQ_HAVE_B) ||
                           (wr_opb && st_q == SEQ_HAVE_A);
    end

    // Next pending-operand state.
    always_comb begin
        st_d = st_q;
        if (wr_ctrl || fire) st_d = SEQ_IDLE;
        else if (!single && wr_opa) st_d = SEQ_HAVE_A;
        else if (!single && wr_opb) st_d = SEQ_HAVE_B;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    // R1: a fired calculation leaves nothing pending.
    a_r1_fire_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q == SEQ_IDLE));

    // R4: a control write discards the pending operand.
    a_r4_ctrl_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (st_q == SEQ_IDLE));

endmodule

// File: rtl/mac_datapath.sv
// Multiply and accumulate datapath, in two register stages.
// Stage 1 captures the extended product on a fire and updates the result
// view for the immediate cases. Stage 2 updates the accumulator, the flag
// and, for accumulate/subtract, the view. Assumes W >= 3.
module mac_datapath
    import mac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            fire,
    input  mac_ctrl_t       ctrl,
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    output logic [3*W-1:0]  acc_q,
    output logic [2*W-1:0]  res_q,
    output logic            ovf_q
);

    localparam int AW = 3 * W;
    localparam int RW = 2 * W;
    localparam int PW = 2 * W + 2;

    logic signed [W:0]    ax, bx;
    logic signed [PW-1:0] pfull;
    logic [AW-1:0]        pext, pneg, view_sum;
    mac_kind_e            kind1;
    logic [RW-1:0]        res1;
    logic                 res1_we;

    logic                 s2_v;
    mac_kind_e            s2_kind;
    logic                 s2_unsgn;
    logic [AW-1:0]        s2_p;

    logic [AW:0]          accx, px, sum_x;
    logic [AW-1:0]        sum2;
    logic                 of2;

    // Stage 1 arithmetic: signedness-aware product, extended to AW bits.
    always_comb begin
        ax    = {ctrl.unsgn ? 1'b0 : op_a[W-1], op_a};
        bx    = {ctrl.unsgn ? 1'b0 : op_b[W-1], op_b};
        pfull = ax * bx;
        pext  = {{(AW-PW){pfull[PW-1]}}, pfull};
        pneg  = '0 - pext;
        kind1 = decode_kind(ctrl);
        view_sum = (kind1 == OP_MSU) ? (acc_q - pext) : (acc_q + pext);
    end

    // Stage 1 view value and whether it is written now.
    always_comb begin
        res1_we = 1'b1;
        case (kind1)
            OP_MUL:  res1 = pext[RW-1:0];
            OP_NEG:  res1 = pneg[RW-1:0];
            default: begin
                res1    = view_sum[RW-1:0];
                res1_we = ctrl.view_only;
            end
        endcase
    end

    // Stage 2 arithmetic: accumulator update with overflow in AW+1 bits.
    always_comb begin
        accx  = {s2_unsgn ? 1'b0 : acc_q[AW-1], acc_q};
        px    = {s2_p[AW-1], s2_p};
        sum_x = (s2_kind == OP_MSU) ? (accx - px) : (accx + px);
        of2   = s2_unsgn ? sum_x[AW] : (sum_x[AW] ^ sum_x[AW-1]);
        sum2  = (s2_kind == OP_MSU) ? (sum_x[AW-1:0] - s2_p) : (sum_x[AW-1:0] + s2_p);
    end

    // Pipeline, accumulator, view and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            s2_v     <= 1'b0;
            s2_kind  <= OP_MUL;
            s2_unsgn <= 1'b0;
            s2_p     <= '0;
            acc_q    <= '0;
            res_q    <= '0;
            ovf_q    <= 1'b0;
        end else begin
            s2_v <= fire && !ctrl.view_only;
            if (fire) begin
                s2_kind  <= kind1;
                s2_unsgn <= ctrl.unsgn;
                s2_p     <= pext;
                if (res1_we) res_q <= res1;
            end
            if (s2_v) begin
                case (s2_kind)
                    OP_MUL: acc_q <= s2_p;
                    OP_NEG: acc_q <= '0 - s2_p;
                    default: begin
                        acc_q <= sum_x[AW-1:0];
                        ovf_q <= of2;
                        res_q <= sum2[RW-1:0];
                    end
                endcase
            end
        end
    end

    // R6/R8: the accumulator moves only on a stage-2 update or a clear.
    a_r6_acc_only_in_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s2_v && !clr) |=> $stable(acc_q));

    // R10: the flag moves only on an accumulating stage 2 or a clear.
    a_r10_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(s2_v && (s2_kind == OP_MAC || s2_kind == OP_MSU))) |=> $stable(ovf_q));

    // R8: an accumulator-preserving fire never schedules stage 2.
    a_r8_view_only_no_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctrl.view_only && !clr) |=> !s2_v);

endmodule

// File: rtl/mac_unit.sv
// Top level of the register-triggered multiply-accumulate unit. It holds the
// operand and control registers, decodes writes, and provides the
// combinational read multiplexer. Assumes BUS_W >= W and BUS_W >= 7.
module mac_unit
    import mac_pkg::*;
#(
    parameter int W     = 16,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [BUS_W-1:0] rd_data
);

    localparam int AW = 3 * W;
    localparam int RW = 2 * W;

    logic            wr_ctrl, wr_opa, wr_opb, clr, fire;
    logic [W-1:0]    opa_q, opb_q, opa_use, opb_use;
    mac_ctrl_t       ctrl_q;
    logic [AW-1:0]   acc_q;
    logic [RW-1:0]   res_q;
    logic            ovf_q;

    // Write decode; result and accumulator addresses decode to nothing.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
        wr_opa  = wr_en && (wr_addr == ADR_OPA);
        wr_opb  = wr_en && (wr_addr == ADR_OPB);
        clr     = wr_ctrl && wr_data[CTRL_CLR_BIT];
        opa_use = wr_opa ? wr_data[W-1:0] : opa_q;
        opb_use = wr_opb ? wr_data[W-1:0] : opb_q;
    end

    // Operand and control registers; clear zeroes the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q  <= '0;
            opb_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= mac_ctrl_t'(wr_data[CTRL_FIELDS-1:0]);
            if (clr) begin
                opa_q <= '0;
                opb_q <= '0;
            end else begin
                if (wr_opa) opa_q <= wr_data[W-1:0];
                if (wr_opb) opb_q <= wr_data[W-1:0];
            end
        end
    end

    mac_opseq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_opa  (wr_opa),
        .wr_opb  (wr_opb),
        .wr_ctrl (wr_ctrl),
        .single  (ctrl_q.single),
        .fire    (fire)
    );

    mac_datapath #(.W(W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .fire  (fire),
        .ctrl  (ctrl_q),
        .op_a  (opa_use),
        .op_b  (opb_use),
        .acc_q (acc_q),
        .res_q (res_q),
        .ovf_q (ovf_q)
    );

    // Read multiplexer; narrower fields are zero-extended.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL: begin
                rd_data[CTRL_FIELDS-1:0] = ctrl_q;
                rd_data[CTRL_OVF_BIT]    = ovf_q;
            end
            ADR_OPA: rd_data = BUS_W'(opa_q);
            ADR_OPB: rd_data = BUS_W'(opb_q);
            ADR_RLO: rd_data = BUS_W'(res_q[0 +: W]);
            ADR_RHI: rd_data = BUS_W'(res_q[W +: W]);
            ADR_AC0: rd_data = BUS_W'(acc_q[0 +: W]);
            ADR_AC1: rd_data = BUS_W'(acc_q[W +: W]);
            default: rd_data = BUS_W'(acc_q[2*W +: W]);
        endcase
    end

    // R5: a clear leaves every data register and the flag at zero.
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (opa_q == '0 && opb_q == '0 && acc_q == '0 && res_q == '0 && !ovf_q));

    // R12: writes to the read-only addresses leave the operands alone.
    a_r12_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADR_RLO) |=> ($stable(opa_q) && $stable(opb_q)));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

    localparam int W = 4;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [BW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint m_acc, m_res;
    bit     m_ovf;

    mac_unit #(.W(W), .BUS_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output longint v);
        rd_addr = a;
        #1;
        v = longint'(rd_data);
    endtask

    task automatic rd_res(output longint v);
        longint lo, hi;
        rd(3'd3, lo); rd(3'd4, hi);
        v = (hi << 4) | lo;
    endtask

    task automatic rd_acc(output longint v);
        longint w0, w1, w2;
        rd(3'd5, w0); rd(3'd6, w1); rd(3'd7, w2);
        v = (w2 << 8) | (w1 << 4) | w0;
    endtask

    task automatic rd_ovf(output longint v);
        longint c;
        rd(3'd0, c);
        v = (c >> 6) & 1;
    endtask

    function automatic longint sx4(input longint v, input bit u);
        return (u || v < 8) ? v : v - 16;
    endfunction

    // Two-operand calculation in mode m with signedness u, checked at both read points.
    task automatic do_op(input int a, input int b, input bit u, input int m);
        bit view, sub, mac, imm;
        longint p, s_old, nv, got, acc_before;
        view = m[2]; sub = m[1]; mac = m[0];
        if (sub && !mac && u) sub = 1'b0;           // R7: unsigned negate is multiply
        p = sx4(a, u) * sx4(b, u);
        s_old = u ? m_acc : ((m_acc >= 2048) ? m_acc - 4096 : m_acc);
        acc_before = m_acc;
        imm = view || !mac;
        if (!mac) begin
            m_res = (sub ? -p : p) & 255;
            if (!view) m_acc = (sub ? -p : p) & 4095;
        end else if (view) begin
            m_res = (sub ? s_old - p : s_old + p) & 255;
        end else begin
            nv = sub ? s_old - p : s_old + p;
            m_ovf = u ? (nv < 0 || nv > 4095) : (nv < -2048 || nv > 2047);
            m_res = (sub ? s_old - 2 * p : s_old + 2 * p) & 255;
            m_acc = nv & 4095;
        end
        wr(3'd1, BW'(a));
        wr(3'd2, BW'(b));
        idle();
        if (imm) begin rd_res(got); chk("R6/R7/R8/R13", "view first cycle", got, m_res); end
        if (!view) begin rd_acc(got); chk("R6", "acc wait cycle", got, acc_before); end
        @(posedge clk); @(negedge clk);
        rd_res(got); chk("R7/R9/R13", "view", got, m_res);
        rd_acc(got); chk("R8/R9/R13", "acc", got, m_acc);
        rd_ovf(got); chk("R10", "overflow flag", got, longint'(m_ovf));
    endtask

    task automatic clear_with(input logic [BW-1:0] c);
        wr(3'd0, c | 8'h20);
        idle();
        m_acc = 0; m_res = 0; m_ovf = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        longint v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R5", "reset value", v, 0);
        end

        // R1: B then A triggers; R2: rewriting A is harmless.
        clear_with(8'h00);
        wr(3'd1, 8'd3); wr(3'd1, 8'd5); idle(); @(negedge clk);
        rd_acc(v); chk("R2", "no trigger on rewrite", v, 0);
        wr(3'd2, 8'd2); idle(); @(negedge clk);
        rd_acc(v); chk("R2", "rewritten A used", v, 10);
        wr(3'd2, 8'd3); wr(3'd1, 8'd4); idle(); @(negedge clk);
        rd_acc(v); chk("R1", "B then A", v, 12);

        // R4: control write drops the pending operand.
        wr(3'd1, 8'd2); wr(3'd0, 8'h00); wr(3'd2, 8'd3); idle(); @(negedge clk);
        rd_acc(v); chk("R4", "pending dropped", v, 12);
        wr(3'd1, 8'd5); idle(); @(negedge clk);
        rd_acc(v); chk("R4", "fresh pair", v, 15);

        // R3: one-operand mode uses the stored other operand.
        wr(3'd0, 8'h10); wr(3'd1, 8'd7); idle(); @(negedge clk);
        rd_acc(v); chk("R3", "A alone", v, 21);
        wr(3'd2, 8'd2); idle(); @(negedge clk);
        rd_acc(v); chk("R3", "B alone", v, 14);

        // R11: consecutive triggers, signed accumulate, one-operand mode.
        clear_with(8'h11);
        wr(3'd2, 8'd3); wr(3'd1, 8'd1); wr(3'd1, 8'd2); wr(3'd1, 8'd3);
        idle(); @(negedge clk);
        rd_acc(v); chk("R11", "back-to-back sum", v, 18);
        rd_ovf(v); chk("R11", "no overflow", v, 0);

        // R12: writes to read-only addresses change nothing.
        rd_res(m_res);
        for (int a = 3; a < 8; a++) wr(3'(a), 8'hFF);
        idle(); @(negedge clk);
        rd_acc(v); chk("R12", "acc kept", v, 18);
        rd_res(v); chk("R12", "view kept", v, m_res);
        rd(3'd1, v); chk("R12", "A kept", v, 3);

        // R5: clear zeroes data and reads back as 0.
        wr(3'd0, 8'h20); idle();
        rd_acc(v); chk("R5", "acc cleared", v, 0);
        rd_res(v); chk("R5", "view cleared", v, 0);
        rd(3'd1, v); chk("R5", "A cleared", v, 0);
        rd(3'd2, v); chk("R5", "B cleared", v, 0);
        rd(3'd0, v); chk("R5", "clear bit self-clears", v, 0);

        // Exhaustive sweep: both signednesses, all mode codes, all pairs.
        for (int u = 0; u < 2; u++) begin
            for (int m = 0; m < 8; m++) begin
                clear_with(BW'((u << 3) | m));
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        do_op(a, b, u[0], m);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule